// File: doc/BRIEF.md
# CAN Bit Timing and Resynchronization Unit

This unit produces the bit framing for a node on a CAN-style serial bus. A prescaler divides the core clock into time quanta, and a three-state sequencer steps each bit through a one-quantum synchronization segment, a first timing segment and a second timing segment. The receive line is sampled once per bit, at the boundary between the two timing segments. A strobe marks the end of every bit, and the transmit side uses it to launch the next bit.

The sequencer aligns to the bus on recessive-to-dominant transitions of the already synchronized receive line. While the caller reports the bus as idle, such an edge restarts the bit from the synchronization segment (hard synchronization). During a frame, an edge that arrives late lengthens the first timing segment, and an edge that arrives early shortens the second. Each correction is capped by the jump width. A combinational check flags timing fields that fall outside the legal ranges.

Sequencer states: `SEG_SYNC` (synchronization quantum), `SEG_TS1` (first timing segment), `SEG_TS2` (second timing segment). The transitions are:
- SYNC→TS1 at the end of the quantum.
- TS1→TS2 at the end of the last TS1 quantum, where the line is sampled.
- TS2→SYNC at the end of the last TS2 quantum, where the bit ends.
- Any state→SYNC on a hard synchronization.

Top module: `can_bit_timer`

## Requirements
- R1: One time quantum lasts 2×(`brp`+1) clock cycles. `tq_tick` pulses for exactly one cycle per quantum and appears one cycle after the last clock of the quantum.
- R2: A bit lasts `tseg1`+`tseg2`+3 quanta: one sync quantum, then `tseg1`+1 quanta of TS1, then `tseg2`+1 quanta of TS2. At the last clock of TS1, `rx_sync` is captured. On the next cycle, `sample_stb` pulses for one cycle and `sample_bit` shows the captured value. `sample_bit` holds its value between samples and resets to 1.
- R3: `tx_stb` pulses for one cycle, one clock after the last clock of each bit's TS2. Without edges, consecutive pulses are exactly one bit time apart.
- R4: With `bus_idle`=1, a falling edge on `rx_sync` (1 in the previous cycle, 0 now) restarts the quantum counter and the bit. The cycle after the edge is the first clock of a sync quantum, whatever the jump width or the previous phase.
- R5: A rising edge of `rx_sync` never changes the timing.
- R6: With `bus_idle`=0, a falling edge in the q-th quantum of TS1 (q counted from 1) lengthens TS1 of that bit by min(q, `sjw`+1) quanta.
- R7: With `bus_idle`=0, a falling edge in TS2 shortens TS2 by min(r, `sjw`+1) quanta. Here r is the number of TS2 quanta left after the one holding the edge, so the bit ends no earlier than the end of that quantum.
- R8: Between two sample points at most one resynchronization takes effect. Later falling edges are ignored until the next sample point. A hard synchronization clears this limit.
- R9: `cfg_err` is 1 when any of these holds: TS1 is outside 2..16 quanta, TS2 is outside 2..8 quanta, the bit is outside 8..25 quanta, or `tseg1` is not greater than `tseg2`.
- R10: During reset, `tq_tick`, `sample_stb` and `tx_stb` are 0 and `sample_bit` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| brp | input | 6 | Prescaler field; quantum = 2×(brp+1) clocks |
| tseg1 | input | 4 | First timing segment length minus one, in quanta |
| tseg2 | input | 3 | Second timing segment length minus one, in quanta |
| sjw | input | 2 | Jump width minus one, in quanta |
| rx_sync | input | 1 | Receive line, already synchronized to clk (1 = recessive) |
| bus_idle | input | 1 | High while the bus is idle; enables hard synchronization |
| tq_tick | output | 1 | One-cycle pulse per time quantum |
| sample_stb | output | 1 | One-cycle pulse after each sample point |
| sample_bit | output | 1 | Value captured at the latest sample point |
| tx_stb | output | 1 | One-cycle pulse at the end of each bit |
| cfg_err | output | 1 | Timing fields outside legal ranges |

## Verification
The bench places falling edges in TS1 under two jump widths, so that both the phase error and the jump width act as the limiting term. A sequencer that ignored the cap, or that counted the phase error off by one quantum, would move the sample point by a whole quantum. Early edges are placed in TS2 so that the shortening either stops at the current quantum or is capped by the jump width; a wrong floor would end the bit too early or not at all. A second edge inside the same TS1, and rising edges inside TS1 and TS2, must leave every sample and bit-end strobe on its nominal cycle, which catches double correction and edge-polarity mistakes. The bench also checks the configuration flag at both legal extremes and on each illegal rule.

// File: rtl/cbt_pkg.sv
package cbt_pkg;

    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_TS1  = 2'd1,
        SEG_TS2  = 2'd2
    } seg_e;

    localparam int TS1_MIN_Q = 2;
    localparam int TS1_MAX_Q = 16;
    localparam int TS2_MIN_Q = 2;
    localparam int TS2_MAX_Q = 8;
    localparam int BIT_MIN_Q = 8;
    localparam int BIT_MAX_Q = 25;

endpackage

// File: rtl/cbt_cfg_check.sv
module cbt_cfg_check
    import cbt_pkg::*;
#(
    parameter int TS1_W = 4,
    parameter int TS2_W = 3
) (
    input  logic [TS1_W-1:0] tseg1,
    input  logic [TS2_W-1:0] tseg2,
    output logic             cfg_err
);
    localparam int SUM_W = ((TS1_W > TS2_W) ? TS1_W : TS2_W) + 2;

    logic [SUM_W-1:0] q1;
    logic [SUM_W-1:0] q2;
    logic [SUM_W-1:0] qbit;

    always_comb begin
        q1   = SUM_W'(tseg1) + 1'b1;
        q2   = SUM_W'(tseg2) + 1'b1;
        qbit = q1 + q2 + 1'b1;
        cfg_err = (q1 < SUM_W'(TS1_MIN_Q)) || (q1 > SUM_W'(TS1_MAX_Q))
               || (q2 < SUM_W'(TS2_MIN_Q)) || (q2 > SUM_W'(TS2_MAX_Q))
               || (qbit < SUM_W'(BIT_MIN_Q)) || (qbit > SUM_W'(BIT_MAX_Q))
               || (q1 <= q2);
    end

endmodule

// File: rtl/cbt_prescaler.sv
module cbt_prescaler #(
    parameter int BRP_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BRP_W-1:0] brp,
    input  logic             restart,
    output logic             tick
);
    localparam int CNT_W = BRP_W + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    // last count of a quantum is 2*(brp+1)-1 = 2*brp+1
    assign lim  = {brp, 1'b1};
    assign tick = (cnt >= lim);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R1
    tq_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/cbt_edge_det.sv
module cbt_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic rx,
    output logic fall
);
    logic rx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= 1'b1;
        end else begin
            rx_q <= rx;
        end
    end

    assign fall = rx_q & ~rx;

    // R5
    fall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/cbt_seg_fsm.sv
module cbt_seg_fsm
    import cbt_pkg::*;
#(
    parameter int TS1_W = 4,
    parameter int TS2_W = 3,
    parameter int SJW_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             fall,
    input  logic             idle,
    input  logic             rx,
    input  logic [TS1_W-1:0] tseg1,
    input  logic [TS2_W-1:0] tseg2,
    input  logic [SJW_W-1:0] sjw,
    output logic             hard_sync,
    output logic             tq_tick_o,
    output logic             sample_stb_o,
    output logic             sample_bit_o,
    output logic             tx_stb_o
);
    localparam int MAX_LEN = (1 << TS1_W) + (1 << SJW_W);
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    seg_e             state, state_n;
    logic [CNT_W-1:0] qcnt, qcnt_n;
    logic [CNT_W-1:0] len1, len1_n;
    logic [CNT_W-1:0] len2, len2_n;
    logic             rs_done, rs_done_n;
    logic             smp, bstart;

    logic [CNT_W-1:0] cfg1, cfg2, jump;
    logic [CNT_W-1:0] err1, adj1, rem2, adj2;

    // segment lengths and the correction limit in quanta
    always_comb begin
        cfg1 = CNT_W'(tseg1) + 1'b1;
        cfg2 = CNT_W'(tseg2) + 1'b1;
        jump = CNT_W'(sjw) + 1'b1;
        err1 = qcnt + 1'b1;
        adj1 = (err1 < jump) ? err1 : jump;
        if (qcnt + 1'b1 >= len2) begin
            rem2 = '0;
        end else begin
            rem2 = len2 - qcnt - 1'b1;
        end
        adj2 = (rem2 < jump) ? rem2 : jump;
    end

    // next-state logic
    always_comb begin
        state_n   = state;
        qcnt_n    = qcnt;
        len1_n    = len1;
        len2_n    = len2;
        rs_done_n = rs_done;
        smp       = 1'b0;
        bstart    = 1'b0;
        hard_sync = idle && fall;

        if (hard_sync) begin
            state_n   = SEG_SYNC;
            qcnt_n    = '0;
            rs_done_n = 1'b0;
            len1_n    = cfg1;
            len2_n    = cfg2;
        end else begin
            if (fall && !rs_done) begin
                unique case (state)
                    SEG_SYNC: ;
                    SEG_TS1: begin
                        len1_n    = len1 + adj1;
                        rs_done_n = 1'b1;
                    end
                    SEG_TS2: begin
                        len2_n    = len2 - adj2;
                        rs_done_n = 1'b1;
                    end
                endcase
            end
            if (tick) begin
                unique case (state)
                    SEG_SYNC: begin
                        state_n = SEG_TS1;
                        qcnt_n  = '0;
                        len1_n  = cfg1;
                        len2_n  = cfg2;
                    end
                    SEG_TS1: begin
                        if (qcnt + 1'b1 >= len1_n) begin
                            state_n   = SEG_TS2;
                            qcnt_n    = '0;
                            smp       = 1'b1;
                            rs_done_n = 1'b0;
                        end else begin
                            qcnt_n = qcnt + 1'b1;
                        end
                    end
                    SEG_TS2: begin
                        if (qcnt + 1'b1 >= len2_n) begin
                            state_n = SEG_SYNC;
                            qcnt_n  = '0;
                            bstart  = 1'b1;
                        end else begin
                            qcnt_n = qcnt + 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SEG_SYNC;
            qcnt    <= '0;
            len1    <= '0;
            len2    <= '0;
            rs_done <= 1'b0;
        end else begin
            state   <= state_n;
            qcnt    <= qcnt_n;
            len1    <= len1_n;
            len2    <= len2_n;
            rs_done <= rs_done_n;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tq_tick_o    <= 1'b0;
            sample_stb_o <= 1'b0;
            sample_bit_o <= 1'b1;
            tx_stb_o     <= 1'b0;
        end else begin
            tq_tick_o    <= tick;
            sample_stb_o <= smp;
            tx_stb_o     <= bstart;
            if (smp) begin
                sample_bit_o <= rx;
            end
        end
    end

    // R2
    sample_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb_o |=> !sample_stb_o);

    // R2
    sample_then_ts2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb_o |-> state == SEG_TS2);

    // R3
    tx_in_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stb_o |-> state == SEG_SYNC);

    // R6
    ts1_growth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEG_TS1 && fall && !rs_done && !idle) |=> (len1 > $past(len1)));

    // R7
    ts2_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEG_TS2 && fall && !rs_done && !idle) |=> (len2 <= $past(len2)));

    // R8
    one_resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEG_TS2 && rs_done && !idle) |=> (len2 == $past(len2)));

endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
    parameter int BRP_W = 6,
    parameter int TS1_W = 4,
    parameter int TS2_W = 3,
    parameter int SJW_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BRP_W-1:0] brp,
    input  logic [TS1_W-1:0] tseg1,
    input  logic [TS2_W-1:0] tseg2,
    input  logic [SJW_W-1:0] sjw,
    input  logic             rx_sync,
    input  logic             bus_idle,
    output logic             tq_tick,
    output logic             sample_stb,
    output logic             sample_bit,
    output logic             tx_stb,
    output logic             cfg_err
);
    logic tick;
    logic fall;
    logic hard_sync;

    cbt_prescaler #(.BRP_W(BRP_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .brp     (brp),
        .restart (hard_sync),
        .tick    (tick)
    );

    cbt_edge_det u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .rx    (rx_sync),
        .fall  (fall)
    );

    cbt_seg_fsm #(.TS1_W(TS1_W), .TS2_W(TS2_W), .SJW_W(SJW_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .fall         (fall),
        .idle         (bus_idle),
        .rx           (rx_sync),
        .tseg1        (tseg1),
        .tseg2        (tseg2),
        .sjw          (sjw),
        .hard_sync    (hard_sync),
        .tq_tick_o    (tq_tick),
        .sample_stb_o (sample_stb),
        .sample_bit_o (sample_bit),
        .tx_stb_o     (tx_stb)
    );

    cbt_cfg_check #(.TS1_W(TS1_W), .TS2_W(TS2_W)) u_cfg (
        .tseg1   (tseg1),
        .tseg2   (tseg2),
        .cfg_err (cfg_err)
    );

endmodule

// File: tb/tb_can_bit_timer.sv
module tb_can_bit_timer;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] brp = 6'd0;
    logic [3:0] tseg1 = 4'd4;
    logic [2:0] tseg2 = 3'd3;
    logic [1:0] sjw = 2'd0;
    logic       rx = 1'b1;
    logic       idle = 1'b1;
    logic       tq_tick, sample_stb, sample_bit, tx_stb, cfg_err;

    can_bit_timer dut (
        .clk(clk), .rst_n(rst_n), .brp(brp), .tseg1(tseg1), .tseg2(tseg2),
        .sjw(sjw), .rx_sync(rx), .bus_idle(idle), .tq_tick(tq_tick),
        .sample_stb(sample_stb), .sample_bit(sample_bit), .tx_stb(tx_stb),
        .cfg_err(cfg_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    int    n0 = 0;
    bit    mon_en = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R10";
    int    exp_s_cyc[$];
    bit    exp_s_bit[$];
    int    exp_t_cyc[$];
    int    ec;
    bit    eb;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (mon_en) begin
            if (sample_stb) begin
                if (exp_s_cyc.size() == 0) begin
                    chk(1'b0, {"R2 ", cur_req}, "unexpected sample at cycle", cyc - n0, -1);
                end else begin
                    ec = exp_s_cyc.pop_front();
                    eb = exp_s_bit.pop_front();
                    chk(cyc == ec, {"R2 ", cur_req}, "sample offset", cyc - n0, ec - n0);
                    chk(sample_bit == eb, {"R2 ", cur_req}, "sample value", int'(sample_bit), int'(eb));
                end
            end
            if (tx_stb) begin
                if (exp_t_cyc.size() == 0) begin
                    chk(1'b0, {"R3 ", cur_req}, "unexpected bit end at cycle", cyc - n0, -1);
                end else begin
                    ec = exp_t_cyc.pop_front();
                    chk(cyc == ec, {"R3 ", cur_req}, "bit end offset", cyc - n0, ec - n0);
                end
            end
        end
    end

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic push_s(input int off, input bit b);
        exp_s_cyc.push_back(n0 + off);
        exp_s_bit.push_back(b);
    endtask

    task automatic push_t(input int off);
        exp_t_cyc.push_back(n0 + off);
    endtask

    // hard synchronization on an idle bus: R4
    task automatic start_case(input int b, input int t1, input int t2,
                              input int s, input string tag);
        @(negedge clk);
        brp = 6'(b); tseg1 = 4'(t1); tseg2 = 3'(t2); sjw = 2'(s);
        idle = 1'b1; rx = 1'b1; cur_req = tag;
        repeat (7) @(negedge clk);
        rx = 1'b0;
        n0 = cyc + 1;
        @(negedge clk);
        idle = 1'b0;
        @(negedge clk);
        mon_en = 1'b1;
    endtask

    task automatic set_rx(input int off, input bit v);
        wait_to(n0 + off);
        rx = v;
    endtask

    task automatic end_case(input int last_off);
        wait_to(n0 + last_off + 2);
        chk(exp_s_cyc.size() == 0, cur_req, "samples missing", exp_s_cyc.size(), 0);
        chk(exp_t_cyc.size() == 0, {"R3 ", cur_req}, "bit ends missing", exp_t_cyc.size(), 0);
        mon_en = 1'b0;
        exp_s_cyc.delete(); exp_s_bit.delete(); exp_t_cyc.delete();
    endtask

    task automatic cfg_case(input int t1, input int t2, input bit expv);
        @(negedge clk);
        tseg1 = 4'(t1); tseg2 = 3'(t2);
        #1;
        chk(cfg_err == expv, "R9", "cfg_err", int'(cfg_err), int'(expv));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(tq_tick == 1'b0, "R10", "tq_tick in reset", int'(tq_tick), 0);
        chk(sample_stb == 1'b0, "R10", "sample_stb in reset", int'(sample_stb), 0);
        chk(tx_stb == 1'b0, "R10", "tx_stb in reset", int'(tx_stb), 0);
        chk(sample_bit == 1'b1, "R10", "sample_bit in reset", int'(sample_bit), 1);
        rst_n = 1'b1;

        // R9 configuration legality
        cfg_case(4, 3, 1'b0);
        cfg_case(3, 3, 1'b1);
        cfg_case(2, 1, 1'b1);
        cfg_case(4, 0, 1'b1);
        cfg_case(15, 7, 1'b0);
        cfg_case(0, 0, 1'b1);

        // nominal timing, hard sync, rising edge in TS2 ignored: R4 R5 R1
        start_case(0, 4, 3, 0, "R4,R5");
        push_s(12, 1'b0); push_s(32, 1'b1); push_s(52, 1'b1);
        push_t(20); push_t(40);
        wait_to(n0 + 2);
        chk(tq_tick == 1'b1, "R1", "tq_tick at quantum end", int'(tq_tick), 1);
        wait_to(n0 + 3);
        chk(tq_tick == 1'b0, "R1", "tq_tick one cycle", int'(tq_tick), 0);
        set_rx(15, 1'b1);
        end_case(52);

        // late edge in TS1, limited by jump width: R6
        start_case(0, 4, 3, 0, "R6");
        push_s(12, 1'b1); push_s(34, 1'b0); push_s(54, 1'b0);
        push_t(20); push_t(42);
        set_rx(5, 1'b1);
        set_rx(24, 1'b0);
        end_case(54);

        // late edge in TS1, limited by phase error: R6
        start_case(0, 4, 3, 3, "R6");
        push_s(12, 1'b1); push_s(36, 1'b0); push_s(56, 1'b0);
        push_t(20); push_t(44);
        set_rx(5, 1'b1);
        set_rx(24, 1'b0);
        end_case(56);

        // early edge in TS2, limited by jump width: R7
        start_case(0, 4, 3, 0, "R7");
        push_s(12, 1'b1); push_s(32, 1'b1); push_s(50, 1'b0); push_s(70, 1'b0);
        push_t(20); push_t(38); push_t(58);
        set_rx(5, 1'b1);
        set_rx(34, 1'b0);
        end_case(70);

        // early edge in TS2, floor at the edge quantum: R7
        start_case(0, 4, 3, 3, "R7");
        push_s(12, 1'b1); push_s(32, 1'b1); push_s(48, 1'b0);
        push_t(20); push_t(36);
        set_rx(5, 1'b1);
        set_rx(34, 1'b0);
        end_case(48);

        // second edge before the sample point ignored: R8
        start_case(0, 4, 3, 3, "R8");
        push_s(12, 1'b1); push_s(36, 1'b0); push_s(56, 1'b0);
        push_t(20); push_t(44);
        set_rx(5, 1'b1);
        set_rx(24, 1'b0);
        set_rx(25, 1'b1);
        set_rx(26, 1'b0);
        end_case(56);

        // larger prescaler, rising edge in TS1 ignored: R1 R2 R5
        start_case(1, 6, 2, 1, "R1,R5");
        push_s(32, 1'b1); push_s(76, 1'b1);
        push_t(44);
        wait_to(n0 + 4);
        chk(tq_tick == 1'b1, "R1", "tq_tick after 4 clocks", int'(tq_tick), 1);
        wait_to(n0 + 6);
        chk(tq_tick == 1'b0, "R1", "tq_tick mid quantum", int'(tq_tick), 0);
        set_rx(8, 1'b1);
        end_case(76);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule